// File: doc/BRIEF.md
# Bit-Steered Instruction Sequencer

This block is the control unit of a small accumulator machine. It does not decode an opcode. Each bit of the instruction directly chooses where one store sends its word. The two stores are a slow main memory and a small file of fast registers. Either store can feed the arithmetic unit, or it can feed the control path. When a store feeds the control path, its word becomes, or modifies, the next instruction. Indexing, jumps and subroutine links are all built the same way: a fast register is added into the incoming instruction word or into the address counter, or the counter is written out to a fast register.

The block holds three registers:
- an incoming-instruction register;
- an execute register;
- an address counter, a whole word whose 13-bit address field wraps.

Each word time takes two clock cycles. The transfer cycle moves one word: the block asserts the store strobes and captures the next instruction. The gap cycle copies the incoming instruction into the execute register, in parallel. In the same cycle it reloads the counter with that instruction word, with its address field advanced by two. The counter keeps the instruction's function bits, so an instruction fetched from the counter repeats its own function. The `step` input is the word-time enable; while it is low nothing changes and no strobe is raised. The arithmetic datapath and the memories sit outside the block; read data returns combinationally during the transfer cycle.

Instruction word layout (27 bits at default parameters):

| Bits | Field |
|---|---|
| [12:0] | address |
| [16:13] | fast-register number |
| 17 | E |
| 18 | D |
| 19 | K |
| 20 | A |
| [26:21] | arithmetic function bits |

Top module: `bitsteer_sequencer`

## Requirements
- R1: While `rst_n` is low, and after release until the first cycle with `step` high, `instr_word` is 0 and `link_data` is 0, and no strobe is raised. The first transfer cycle after reset reads main memory at address 0.
- R2: The cycles with `step` high alternate between gap and transfer, starting with a gap. Strobes and routing flags are raised only in a transfer cycle with `step` high. A cycle with `step` low changes no register.
- R3: In a transfer, `mem_addr` is the address field of the execute word. When A=1 and D=1, `mem_we` is raised. In every other case `mem_re` is raised; when A=0, main memory always feeds control and D has no effect.
- R4: In a transfer, `fast_addr` is the fast-register field. `fast_re` is raised when E=0 and `fast_we` when E=1.
- R5: With A=0, and not (K=1 and E=0), the next `instr_word` equals `mem_rdata` unmodified. `fast_to_arith` is high exactly when K=0 and E=0.
- R6: With A=0, K=1, E=0, the next `instr_word` is `mem_rdata + fast_rdata` modulo 2^27.
- R7: With A=1, and not (K=1 and E=0), the next `instr_word` equals the counter word (`link_data`). `mem_to_arith` is high whenever A=1.
- R8: With A=1, K=1, E=0, the next `instr_word` is the counter word plus `fast_rdata`, modulo 2^27.
- R9: On each gap cycle the counter takes `instr_word`, with bits [12:0] replaced by (bits [12:0] + 2) mod 8192 and bits [26:13] unchanged.
- R10: With K=1 and E=1, `link_store` is raised and `link_data` carries the counter word, to be written into the addressed fast register. No index modification takes place.
- R11: On each gap cycle the execute register takes `instr_word`. From the next cycle, `mem_addr`, `fast_addr` and `arith_op` (bits [26:21]) show its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step | input | 1 | Word-time enable |
| mem_rdata | input | 27 | Word read from main memory |
| fast_rdata | input | 27 | Word read from the addressed fast register |
| mem_addr | output | 13 | Main-memory address |
| mem_re | output | 1 | Main-memory read strobe |
| mem_we | output | 1 | Main-memory write strobe |
| fast_addr | output | 4 | Fast-register number |
| fast_re | output | 1 | Fast-register read strobe |
| fast_we | output | 1 | Fast-register write strobe |
| link_store | output | 1 | The fast-register write carries the counter word |
| link_data | output | 27 | Address counter word |
| mem_to_arith | output | 1 | Main-memory word goes to the arithmetic unit |
| fast_to_arith | output | 1 | Fast-register word goes to the arithmetic unit |
| arith_op | output | 6 | Arithmetic function bits of the executing instruction |
| instr_word | output | 27 | Incoming (possibly modified) instruction register |

## Verification
The hardest state to reach is an instruction with A=1 executing while the counter holds a chosen word. An A=1 instruction takes its successor from the counter, so once the machine is in a repeating A=1 loop no word from main memory can steer it again. The bench therefore starts every pattern from reset. The reset word is a jump to address 0; the bench answers that fetch with a crafted instruction. This places each of the sixteen A/K/D/E combinations into the execute register with a known counter value, including addresses next to the 13-bit wrap and index words that carry across the full word. Seeded random segments then run with `step` dropping out and frequent resets, and a word-level model predicts every output.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    PH_GAP  = 1'b0,
    PH_XFER = 1'b1
  } phase_e;
endpackage

// File: rtl/bsq_decode.sv
module bsq_decode #(
  parameter int AW  = 13,
  parameter int FAW = 4,
  parameter int ARW = 6,
  parameter int W   = ARW + AW + FAW + 4
) (
  input  logic [W-1:0]   xw,
  input  logic           active,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_re,
  output logic           mem_we,
  output logic [FAW-1:0] fast_addr,
  output logic           fast_re,
  output logic           fast_we,
  output logic           link_store,
  output logic           mem_to_arith,
  output logic           fast_to_arith,
  output logic           from_cnt,
  output logic           use_index,
  output logic [ARW-1:0] arith_op
);
  localparam int EB = AW + FAW;
  localparam int DB = EB + 1;
  localparam int KB = EB + 2;
  localparam int AB = EB + 3;
  localparam int OB = EB + 4;

  logic bit_a, bit_k, bit_d, bit_e;

  always_comb begin
    bit_a = xw[AB];
    bit_k = xw[KB];
    bit_d = xw[DB];
    bit_e = xw[EB];
    mem_addr      = xw[AW-1:0];
    fast_addr     = xw[EB-1:AW];
    arith_op      = xw[W-1:OB];
    mem_we        = active & bit_a & bit_d;
    mem_re        = active & ~(bit_a & bit_d);
    fast_we       = active & bit_e;
    fast_re       = active & ~bit_e;
    link_store    = active & bit_k & bit_e;
    mem_to_arith  = active & bit_a;
    fast_to_arith = active & ~bit_k & ~bit_e;
    from_cnt      = bit_a;
    use_index     = bit_k & ~bit_e;
  end
endmodule

// File: rtl/bsq_nextword.sv
module bsq_nextword #(
  parameter int W = 27
) (
  input  logic         from_cnt,
  input  logic         use_index,
  input  logic [W-1:0] mem_word,
  input  logic [W-1:0] cnt_word,
  input  logic [W-1:0] fast_word,
  output logic [W-1:0] next_word
);
  logic [W-1:0] base_word;
  logic [W-1:0] addend;

  always_comb begin
    base_word = from_cnt ? cnt_word : mem_word;
    addend    = use_index ? fast_word : '0;
    next_word = base_word + addend;
  end
endmodule

// File: rtl/bsq_counter.sv
module bsq_counter #(
  parameter int AW = 13,
  parameter int W  = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] src,
  output logic [W-1:0] cnt
);
  localparam logic [AW-1:0] STRIDE = AW'(2);

  logic [W-1:0] cnt_d;
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = {src[W-1:AW], src[AW-1:0] + STRIDE};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9
  cnt_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt[AW-1:0] == $past(src[AW-1:0]) + STRIDE) &&
             (cnt[W-1:AW] == $past(src[W-1:AW])));
endmodule

// File: rtl/bitsteer_sequencer.sv
module bitsteer_sequencer
  import bsq_pkg::*;
#(
  parameter int AW  = 13,
  parameter int FAW = 4,
  parameter int ARW = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step,
  input  logic [ARW+AW+FAW+3:0]        mem_rdata,
  input  logic [ARW+AW+FAW+3:0]        fast_rdata,
  output logic [AW-1:0]                mem_addr,
  output logic                         mem_re,
  output logic                         mem_we,
  output logic [FAW-1:0]               fast_addr,
  output logic                         fast_re,
  output logic                         fast_we,
  output logic                         link_store,
  output logic [ARW+AW+FAW+3:0]        link_data,
  output logic                         mem_to_arith,
  output logic                         fast_to_arith,
  output logic [ARW-1:0]               arith_op,
  output logic [ARW+AW+FAW+3:0]        instr_word
);
  localparam int W  = ARW + AW + FAW + 4;
  localparam int EB = AW + FAW;
  localparam int KB = EB + 2;
  localparam int AB = EB + 3;
  localparam int OB = EB + 4;

  logic [1:0]   rst_sync;
  logic         rst_q;
  phase_e       phase_q, phase_d;
  logic [W-1:0] ir_q, ir_d;
  logic [W-1:0] xr_q, xr_d;
  logic [W-1:0] next_word;
  logic [W-1:0] cnt_word;
  logic         active;
  logic         cnt_load;
  logic         from_cnt;
  logic         use_index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign active   = step & (phase_q == PH_XFER);
  assign cnt_load = step & (phase_q == PH_GAP);

  bsq_decode #(.AW(AW), .FAW(FAW), .ARW(ARW), .W(W)) u_decode (
    .xw            (xr_q),
    .active        (active),
    .mem_addr      (mem_addr),
    .mem_re        (mem_re),
    .mem_we        (mem_we),
    .fast_addr     (fast_addr),
    .fast_re       (fast_re),
    .fast_we       (fast_we),
    .link_store    (link_store),
    .mem_to_arith  (mem_to_arith),
    .fast_to_arith (fast_to_arith),
    .from_cnt      (from_cnt),
    .use_index     (use_index),
    .arith_op      (arith_op)
  );

  bsq_nextword #(.W(W)) u_next (
    .from_cnt  (from_cnt),
    .use_index (use_index),
    .mem_word  (mem_rdata),
    .cnt_word  (cnt_word),
    .fast_word (fast_rdata),
    .next_word (next_word)
  );

  bsq_counter #(.AW(AW), .W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_q),
    .load  (cnt_load),
    .src   (ir_q),
    .cnt   (cnt_word)
  );

  always_comb begin
    phase_d = phase_q;
    ir_d    = ir_q;
    xr_d    = xr_q;
    if (step) begin
      if (phase_q == PH_XFER) begin
        ir_d    = next_word;
        phase_d = PH_GAP;
      end else begin
        xr_d    = ir_q;
        phase_d = PH_XFER;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      phase_q <= PH_GAP;
      ir_q    <= '0;
      xr_q    <= '0;
    end else begin
      phase_q <= phase_d;
      ir_q    <= ir_d;
      xr_q    <= xr_d;
    end
  end

  assign instr_word = ir_q;
  assign link_data  = cnt_word;

  // R2
  xfer_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (step && (mem_re || mem_we)) |=> !(mem_re || mem_we));

  // R11
  exec_copy_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (step && phase_q == PH_GAP) |=>
      (arith_op == $past(instr_word[W-1:OB])) && (mem_addr == $past(instr_word[AW-1:0])));

  // R7
  counter_feed_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (active && xr_q[AB] && !(xr_q[KB] && !xr_q[EB])) |=> instr_word == $past(link_data));

  // R5
  mem_feed_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (active && !xr_q[AB] && !(xr_q[KB] && !xr_q[EB])) |=> instr_word == $past(mem_rdata));
endmodule

// File: tb/bitsteer_sequencer_test.sv
`timescale 1ns/1ps
module bitsteer_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step;
  logic [26:0] mem_rdata, fast_rdata;
  logic [12:0] mem_addr;
  logic        mem_re, mem_we;
  logic [3:0]  fast_addr;
  logic        fast_re, fast_we, link_store;
  logic [26:0] link_data;
  logic        mem_to_arith, fast_to_arith;
  logic [5:0]  arith_op;
  logic [26:0] instr_word;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [26:0] m_ir, m_xr, m_cnt;
  logic        m_ph;
  string       ir_tag;
  logic [31:0] seed = 32'h1234_5678;

  bitsteer_sequencer uut (
    .clk(clk), .rst_n(rst_n), .step(step), .mem_rdata(mem_rdata), .fast_rdata(fast_rdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .fast_addr(fast_addr),
    .fast_re(fast_re), .fast_we(fast_we), .link_store(link_store), .link_data(link_data),
    .mem_to_arith(mem_to_arith), .fast_to_arith(fast_to_arith), .arith_op(arith_op),
    .instr_word(instr_word)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL R2 watchdog expired: actual=%0d cycles expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic model_reset();
    m_ir = '0; m_xr = '0; m_cnt = '0; m_ph = 1'b0; ir_tag = "R1 instr_word";
  endtask

  // One clock: drive inputs, compare outputs with the model, advance the model.
  task automatic cycle(input logic st, input logic [26:0] md, input logic [26:0] fd);
    logic act, a, k, d, e;
    logic [26:0] base;
    @(negedge clk);
    step = st; mem_rdata = md; fast_rdata = fd;
    #1;
    act = st & m_ph;
    a = m_xr[20]; k = m_xr[19]; d = m_xr[18]; e = m_xr[17];
    chk("R3 mem_re",        32'(mem_re),        32'(act & ~(a & d)));
    chk("R3 mem_we",        32'(mem_we),        32'(act & a & d));
    chk("R11 mem_addr",     32'(mem_addr),      32'(m_xr[12:0]));
    chk("R4 fast_re",       32'(fast_re),       32'(act & ~e));
    chk("R4 fast_we",       32'(fast_we),       32'(act & e));
    chk("R11 fast_addr",    32'(fast_addr),     32'(m_xr[16:13]));
    chk("R10 link_store",   32'(link_store),    32'(act & k & e));
    chk("R9 link_data",     32'(link_data),     32'(m_cnt));
    chk("R7 mem_to_arith",  32'(mem_to_arith),  32'(act & a));
    chk("R5 fast_to_arith", 32'(fast_to_arith), 32'(act & ~k & ~e));
    chk("R11 arith_op",     32'(arith_op),      32'(m_xr[26:21]));
    chk(ir_tag,             32'(instr_word),    32'(m_ir));
    if (st) begin
      if (m_ph) begin
        base = a ? m_cnt : md;
        if (k & ~e) base = base + fd;
        m_ir = base;
        if (!a) ir_tag = (k & ~e) ? "R6 indexed instr" : "R5 memory instr";
        else    ir_tag = (k & ~e) ? "R8 counter+index" : "R7 counter instr";
        if (k & e) ir_tag = "R10 link no-modify";
        m_ph = 1'b0;
      end else begin
        m_xr  = m_ir;
        m_cnt = {m_ir[26:13], m_ir[12:0] + 13'd2};
        m_ph  = 1'b1;
      end
    end else begin
      ir_tag = "R2 hold";
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0;
    model_reset();
    cycle(1'b1, 27'h5A5A5A5, 27'h1234567);   // step ignored while in reset
    model_reset();
    cycle(1'b0, '0, '0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle(1'b0, 27'h7FFFFFF, 27'h7FFFFFF);
  endtask

  initial begin
    rst_n = 1'b0; step = 1'b0; mem_rdata = '0; fast_rdata = '0;
    model_reset();
    repeat (2) @(negedge clk);

    // Sweep every A/K/D/E combination out of reset with crafted words.
    for (int f = 0; f < 16; f++) begin
      for (int v = 0; v < 8; v++) begin
        logic [26:0] w, fd;
        logic [12:0] ad;
        do_reset();
        ad = (v < 4) ? 13'h1FFE + 13'(v) : 13'(v * 1000);
        w  = {6'((v * 7 + f) % 64), 4'(f), 4'((v * 3 + f) % 16), ad};
        fd = (v == 0) ? 27'h7FFFFFF : 27'(v * 13);
        cycle(1'b1, '0, '0);            // gap: execute the reset jump
        chk("R1 first read addr", 32'(mem_addr), 32'h0);
        cycle(1'b1, w, fd);             // transfer from address 0
        cycle(1'b0, '0, '0);            // hold mid-word
        cycle(1'b1, '0, '0);            // gap: crafted word executes next
        cycle(1'b1, 27'(rnd()), fd);    // transfer with crafted word in execute
        for (int i = 0; i < 6; i++) cycle(1'b1, 27'(rnd()), 27'(rnd() & 32'h3FF));
      end
    end

    // Random segments with step dropouts and periodic resets.
    for (int s = 0; s < 30; s++) begin
      do_reset();
      for (int i = 0; i < 64; i++) begin
        logic [31:0] r;
        r = rnd();
        cycle(r[3:0] != 4'd0, 27'(rnd()), (r[5]) ? 27'(rnd()) : 27'(rnd() & 32'hFF));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule